// File: doc/BRIEF.md
# Wake-up Event Keep-out Gate

This block sits between a set of external wake-up request lines and the power-mode controller. Software pulses an entry trigger when it asks for deep sleep, power down or deep power down. From that cycle a blanking window of fixed length opens. While the window is open, no wake-up request reaches the controller, which is still in the middle of its transition. The same trigger serves all three target modes.

A request that shows up inside the window is not dropped. It is caught in a per-lane latch. Once the window closes, the latch drives the gated output and keeps driving it until the clear input is pulsed. Outside the window, live requests pass to the output without delay. The window has a fixed duration in time, and its length in clock cycles comes from parameters. A designer sets the clock rate and the duration, and the block rounds the cycle count up.

Top module: `wake_keepout_gate`

## Requirements
- R1: After synchronous reset the window is closed, no lane is latched, `pend_o` is 0 and `wake_o` equals `req_i`.
- R2: The window length in cycles is WIN = ceil(WIN_NS * CLK_KHZ / 1e6), which is 1200 at the defaults. `blank_o` is high in the cycle `enter_i` is high and in the following WIN-1 cycles, so it is high for exactly WIN cycles.
- R3: When `enter_i` is pulsed while the window is open, the window restarts at full length from that cycle.
- R4: While `blank_o` is high, every bit of `wake_o` is 0.
- R5: A high `req_i` bit in a cycle where `blank_o` is high sets that lane's latch at the next clock edge.
- R6: When `blank_o` is low, bit i of `wake_o` equals `req_i[i]` OR latch i. A latched lane stays set through any number of cycles without `clear_i`.
- R7: When `blank_o` is low, a request appears on `wake_o` in the same cycle and does not set a latch.
- R8: `clear_i` empties every latch at the next edge. A request in the window during that same cycle is still latched.
- R9: `pend_o` is high exactly when at least one latch is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enter_i | input | 1 | One-cycle pulse from software at low-power entry |
| req_i | input | LANES | Raw wake-up request lines |
| clear_i | input | 1 | Pulse that empties all latched requests |
| wake_o | output | LANES | Gated wake-up lines to the power controller |
| blank_o | output | 1 | Blanking window active |
| pend_o | output | 1 | At least one latched request is held |

## Verification
The properties assume that `enter_i`, `req_i` and `clear_i` are synchronous to `clk` and stable around the edge. They also assume that reset is held for at least one edge before any check applies. The window-length properties assume that no retrigger comes in except through `enter_i`, which the checker treats as the start of a new count. The stimulus changes inputs one time unit after each rising edge. It holds reset for three cycles, and it pulses a retrigger only once the window has already been open for several hundred cycles.

// File: rtl/wake_keepout_pkg.sv
package wake_keepout_pkg;

  // Cycle count for a window of ns nanoseconds at khz kilohertz, rounded up.
  function automatic int unsigned win_cycles(input int unsigned ns, input int unsigned khz);
    longint unsigned prod;
    longint unsigned cyc;
    prod = longint'(ns) * longint'(khz);
    cyc  = (prod + 64'd999999) / 64'd1000000;
    if (cyc == 0) cyc = 1;
    return int'(cyc);
  endfunction

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/wake_keepout_timer.sv
module wake_keepout_timer #(
  parameter int unsigned WIN_CYC = 1200,
  parameter int unsigned CW      = 11
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic blank_o
);

  localparam logic [CW-1:0] RELOAD = CW'(WIN_CYC - 1);

  logic [CW-1:0] left_q;

  // Remaining cycles after the current one; a start reloads from full length.
  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
    end else if (start_i) begin
      left_q <= RELOAD;
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
    end
  end

  assign blank_o = start_i | (left_q != '0);

endmodule

// File: rtl/wake_keepout_lane.sv
module wake_keepout_lane (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  input  logic blank_i,
  input  logic clear_i,
  output logic wake_o,
  output logic held_o
);

  logic held_q;

  // Clear removes the old state; a request caught in the window this cycle survives it.
  always_ff @(posedge clk) begin
    if (rst) begin
      held_q <= 1'b0;
    end else begin
      held_q <= (held_q & ~clear_i) | (req_i & blank_i);
    end
  end

  assign wake_o = ~blank_i & (req_i | held_q);
  assign held_o = held_q;

endmodule

// File: rtl/wake_keepout_gate.sv
module wake_keepout_gate
  import wake_keepout_pkg::*;
#(
  parameter int unsigned LANES   = 4,
  parameter int unsigned CLK_KHZ = 200000,
  parameter int unsigned WIN_NS  = 6000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enter_i,
  input  logic [LANES-1:0] req_i,
  input  logic             clear_i,
  output logic [LANES-1:0] wake_o,
  output logic             blank_o,
  output logic             pend_o
);

  localparam int unsigned WIN_CYC = win_cycles(WIN_NS, CLK_KHZ);
  localparam int unsigned CW      = cnt_width(WIN_CYC);

  logic             blank;
  logic [LANES-1:0] held;

  wake_keepout_timer #(
    .WIN_CYC(WIN_CYC),
    .CW     (CW)
  ) u_timer (
    .clk    (clk),
    .rst    (rst),
    .start_i(enter_i),
    .blank_o(blank)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    wake_keepout_lane u_lane (
      .clk    (clk),
      .rst    (rst),
      .req_i  (req_i[g]),
      .blank_i(blank),
      .clear_i(clear_i),
      .wake_o (wake_o[g]),
      .held_o (held[g])
    );
  end

  assign blank_o = blank;
  assign pend_o  = |held;

endmodule

// File: rtl/wake_keepout_chk.sv
module wake_keepout_chk
  import wake_keepout_pkg::*;
#(
  parameter int unsigned LANES   = 4,
  parameter int unsigned CLK_KHZ = 200000,
  parameter int unsigned WIN_NS  = 6000
) (
  input logic             clk,
  input logic             rst,
  input logic             enter_i,
  input logic [LANES-1:0] req_i,
  input logic             clear_i,
  input logic [LANES-1:0] wake_o,
  input logic             blank_o,
  input logic             pend_o
);

  localparam int unsigned WIN = win_cycles(WIN_NS, CLK_KHZ);

  // Cycles the window has been open since its latest start.
  int unsigned run_q;
  always_ff @(posedge clk) begin
    if (rst) run_q <= 0;
    else if (enter_i) run_q <= 1;
    else if (blank_o && run_q != 0) run_q <= run_q + 1;
    else run_q <= 0;
  end

  // R2
  trig_open_chk: assert property (@(posedge clk) disable iff (rst)
    enter_i |-> blank_o);

  // R2
  win_len_chk: assert property (@(posedge clk) disable iff (rst)
    (blank_o && !enter_i) |-> (run_q != 0 && run_q < WIN));

  // R3
  win_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (run_q != 0 && run_q < WIN) |-> blank_o);

  // R4
  blank_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    blank_o |-> (wake_o == '0));

  // R5
  catch_chk: assert property (@(posedge clk) disable iff (rst)
    (blank_o && (|req_i)) |=> pend_o);

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_o && !clear_i) |=> pend_o);

  // R6
  release_chk: assert property (@(posedge clk) disable iff (rst)
    (!blank_o && pend_o) |-> (wake_o != '0));

  // R7
  pass_chk: assert property (@(posedge clk) disable iff (rst)
    !blank_o |-> ((wake_o & req_i) == req_i));

  // R8
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clear_i && !blank_o) |=> !pend_o);

endmodule

bind wake_keepout_gate wake_keepout_chk #(
  .LANES  (LANES),
  .CLK_KHZ(CLK_KHZ),
  .WIN_NS (WIN_NS)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .enter_i(enter_i),
  .req_i  (req_i),
  .clear_i(clear_i),
  .wake_o (wake_o),
  .blank_o(blank_o),
  .pend_o (pend_o)
);

// File: tb/wake_keepout_gate_bench.sv
`timescale 1ns/1ps
module wake_keepout_gate_bench;

  localparam int LANES   = 4;
  localparam int CLK_KHZ = 200000;
  localparam int WIN_NS  = 6000;
  localparam longint PRODUCT = longint'(WIN_NS) * longint'(CLK_KHZ);
  localparam int WIN = int'((PRODUCT + 999999) / 1000000);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             enter = 1'b0;
  logic [LANES-1:0] req = '0;
  logic             clear = 1'b0;
  logic [LANES-1:0] wake;
  logic             blank;
  logic             pend;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  wake_keepout_gate #(
    .LANES(LANES), .CLK_KHZ(CLK_KHZ), .WIN_NS(WIN_NS)
  ) u_wake_keepout_gate (
    .clk(clk), .rst(rst), .enter_i(enter), .req_i(req), .clear_i(clear),
    .wake_o(wake), .blank_o(blank), .pend_o(pend)
  );

  // Behavioural reference: remaining window cycles and caught requests.
  int               m_left = 0;
  logic [LANES-1:0] m_caught = '0;

  function automatic bit m_open();
    return enter || (m_left > 0);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_left   = 0;
      m_caught = '0;
    end else begin
      bit open_now;
      open_now = m_open();
      if (clear) m_caught = '0;
      if (open_now) m_caught = m_caught | req;
      if (enter) m_left = WIN - 1;
      else if (m_left > 0) m_left = m_left - 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the reference (R4 R6 R7 R9).
  always @(negedge clk) begin
    if (!rst) begin
      logic [LANES-1:0] exp_wake;
      exp_wake = m_open() ? '0 : (req | m_caught);
      chk("R4_R6_R7 wake per cycle", 32'(wake), 32'(exp_wake));
      chk("R2 blank per cycle", 32'(blank), 32'(m_open()));
      chk("R9 pend per cycle", 32'(pend), 32'(|m_caught));
    end
  end

  task automatic drive(input bit e, input logic [LANES-1:0] r, input bit c);
    @(posedge clk);
    #1;
    enter = e;
    req   = r;
    clear = c;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) drive(0, '0, 0);
  endtask

  initial begin
    #(5.0 * 100000);
    fails++;
    $display("FAIL R2 watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    req = 4'b0101;
    @(negedge clk);
    // R1 reset state, requests pass
    chk("R1 wake after reset", 32'(wake), 32'h5);
    chk("R1 blank after reset", 32'(blank), 0);
    chk("R1 pend after reset", 32'(pend), 0);

    // R7 request outside window not latched
    drive(0, '0, 0);
    @(negedge clk);
    chk("R7 no latch outside window", 32'(pend), 0);
    chk("R7 wake drops with request", 32'(wake), 0);

    // R2 window length
    drive(1, '0, 0);
    n = 0;
    for (int k = 0; k < WIN + 5; k++) begin
      @(negedge clk);
      if (blank) n++;
      drive(0, '0, 0);
    end
    chk("R2 window length", 32'(n), 32'(WIN));

    // R4/R5/R6 catch during window, release after
    drive(1, '0, 0);
    idle(100);
    drive(0, 4'b0100, 0);
    @(negedge clk);
    chk("R4 wake blanked", 32'(wake), 0);
    drive(0, '0, 0);
    @(negedge clk);
    chk("R5 pend after catch", 32'(pend), 1);
    idle(WIN);
    @(negedge clk);
    chk("R6 released lane", 32'(wake), 32'h4);
    drive(0, 4'b0001, 0);
    @(negedge clk);
    chk("R6 latched OR live", 32'(wake), 32'h5);
    idle(50);
    @(negedge clk);
    chk("R6 held without clear", 32'(wake), 32'h4);
    drive(0, '0, 1);
    drive(0, '0, 0);
    @(negedge clk);
    chk("R8 clear empties", 32'(pend), 0);
    chk("R8 wake after clear", 32'(wake), 0);

    // R3 retrigger restarts full length
    drive(1, '0, 0);
    n = 0;
    for (int k = 0; k < 400 + WIN + 5; k++) begin
      @(negedge clk);
      if (blank) n++;
      drive(k == 399, '0, 0);
    end
    chk("R3 retrigger length", 32'(n), 32'(400 + WIN));

    // R8 clear and catch in the same window cycle
    drive(1, '0, 0);
    drive(0, 4'b1000, 0);
    idle(10);
    drive(0, 4'b0001, 1);
    drive(0, '0, 0);
    @(negedge clk);
    chk("R8 pend kept by new catch", 32'(pend), 1);
    idle(WIN);
    @(negedge clk);
    chk("R8 only new lane survives", 32'(wake), 32'h1);
    drive(0, '0, 1);
    drive(0, '0, 0);
    @(negedge clk);
    chk("R9 pend low after clear", 32'(pend), 0);

    idle(5);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule